// File: doc/BRIEF.md
# Internal Bus Region Decoder

This block sits on the data-access path of a 16-bit CPU that works in a flat 24-bit byte address space. For each access the CPU presents an address, a read/write flag, a byte/word flag and, for writes, the data. The decoder sends the access to one of three targets: a 2 KB on-chip extension RAM, a 256-byte register window of an on-chip CAN controller, or the external memory interface. It also inserts the wait states the chosen target needs, steers byte lanes, and returns read data with a ready strobe.

One configuration bit, `onchip_en`, switches both on-chip windows on and off. While it is clear, addresses in those windows are not rejected. They go to the external interface like any other address. While it is set, the CAN controller owns two upper port pins, so the external interface drives only 20 address bits. The CPU holds its request steady until it sees ready, so a new access starts only after the previous one has completed.

Top module: `bus_region_decoder`

## Requirements
- R1: With `onchip_en`=1, an access to 0x00E000..0x00E7FF asserts `xram_sel` (and no other select) with `xram_word` = address bits [10:1].
- R2: An extension RAM access returns `rsp_ready`=1 in the same cycle the request is first presented, with `rsp_rdata` taken from `xram_rdata`.
- R3: With `onchip_en`=1, an access to 0x00EF00..0x00EFFF asserts `can_sel` with `can_word` = address bits [7:1]. `rsp_ready` is 0 in the first two cycles and 1 in the third, and read data comes from `can_rdata`.
- R4: With `onchip_en`=0, addresses in both on-chip windows assert `ext_sel` with the full address on `ext_addr`, and never `xram_sel` or `can_sel`.
- R5: Every aligned access outside an enabled on-chip window asserts `ext_sel`. `rsp_ready` then follows `ext_ready` and `rsp_rdata` follows `ext_rdata`.
- R6: While `onchip_en`=1, `ext_addr[23:20]` is driven 0 and `ext_addr[19:0]` carries the request address. While `onchip_en`=0, `ext_addr` carries all 24 bits.
- R7: A byte write sets `tgt_be`=2'b01 at an even address or 2'b10 at an odd address, and places `req_wdata[7:0]` on both halves of `tgt_wdata`. A word access sets `tgt_be`=2'b11 and passes the data unchanged.
- R8: A byte read returns the lane selected by address bit 0 (0 = bits [7:0], 1 = bits [15:8]) in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R9: A word access at an odd address raises `rsp_align_err` and `rsp_ready` in the same cycle and asserts no target select.
- R10: Reset clears a CAN wait count in progress. A CAN request still held after reset waits the full two cycles again.
- R11: A CAN request presented in the cycle right after a completed CAN access again gets exactly two wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| onchip_en | input | 1 | Enables both on-chip windows |
| req_valid | input | 1 | CPU access request, held until ready |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word |
| req_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| rsp_ready | output | 1 | Access complete |
| rsp_rdata | output | 16 | Read data, zero-extended for bytes |
| rsp_align_err | output | 1 | Odd-address word access |
| tgt_we | output | 1 | Write strobe to the selected target |
| tgt_be | output | 2 | Byte-lane enables to the target |
| tgt_wdata | output | 16 | Lane-steered write data |
| xram_sel | output | 1 | Extension RAM select |
| xram_word | output | 10 | Extension RAM word index |
| xram_rdata | input | 16 | Extension RAM read data |
| can_sel | output | 1 | CAN window select |
| can_word | output | 7 | CAN register word index |
| can_rdata | input | 16 | CAN window read data |
| ext_sel | output | 1 | External interface select |
| ext_addr | output | 24 | External address, segment-limited |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External access done |

## Verification
Decoding, lane steering, alignment errors and extension RAM completion are combinational. The bench samples them 2 ns after the negative edge at which the stimulus was applied, so no clock edge falls between stimulus and check. A CAN access becomes ready only after two rising edges. Its checks are taken at three consecutive negative edges, expecting 0, 0 and then 1, and the same three-sample pattern is applied after a mid-access reset and for a back-to-back request. External completion is checked in the same cycle `ext_ready` changes.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_EXT  = 2'd1,
    RGN_XRAM = 2'd2,
    RGN_CAN  = 2'd3
  } rgn_e;
endpackage

// File: rtl/bus_region_map.sv
module bus_region_map
  import bus_dec_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 24,
  parameter int unsigned     XRAM_AW   = 11,
  parameter int unsigned     CAN_AW    = 8,
  parameter logic [ADDR_W-1:0] XRAM_BASE = 'h00E000,
  parameter logic [ADDR_W-1:0] CAN_BASE  = 'h00EF00
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_byte,
  input  logic              onchip_en,
  output rgn_e              rgn,
  output logic              misaligned
);
  logic hit_xram, hit_can;

  assign hit_xram   = (addr[ADDR_W-1:XRAM_AW] == XRAM_BASE[ADDR_W-1:XRAM_AW]);
  assign hit_can    = (addr[ADDR_W-1:CAN_AW]  == CAN_BASE[ADDR_W-1:CAN_AW]);
  assign misaligned = valid && !is_byte && addr[0];

  always_comb begin
    if (!valid || misaligned)        rgn = RGN_NONE;
    else if (onchip_en && hit_xram)  rgn = RGN_XRAM;
    else if (onchip_en && hit_can)   rgn = RGN_CAN;
    else                             rgn = RGN_EXT;
  end
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              is_byte,
  input  logic              odd,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [1:0]        be,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  localparam int unsigned LANE_W = DATA_W / 2;

  always_comb begin
    if (is_byte) begin
      be        = odd ? 2'b10 : 2'b01;
      wdata_out = {2{wdata_in[LANE_W-1:0]}};
      rdata_out = {{LANE_W{1'b0}},
                   (odd ? rdata_in[DATA_W-1:LANE_W] : rdata_in[LANE_W-1:0])};
    end else begin
      be        = 2'b11;
      wdata_out = wdata_in;
      rdata_out = rdata_in;
    end
  end
endmodule

// File: rtl/bus_wait_count.sv
module bus_wait_count #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] need,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == need);
  assign cnt_en = active || (cnt_q != '0);

  always_comb begin
    if (active && !done) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned XRAM_AW    = 11,
  parameter int unsigned CAN_AW     = 8,
  parameter int unsigned SEG_W      = 20,
  parameter int unsigned XRAM_WAITS = 0,
  parameter int unsigned CAN_WAITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              onchip_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_align_err,
  output logic              tgt_we,
  output logic [1:0]        tgt_be,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              xram_sel,
  output logic [XRAM_AW-2:0] xram_word,
  input  logic [DATA_W-1:0] xram_rdata,
  output logic              can_sel,
  output logic [CAN_AW-2:0] can_word,
  input  logic [DATA_W-1:0] can_rdata,
  output logic              ext_sel,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ready
);
  localparam int unsigned MAX_WAITS = (CAN_WAITS > XRAM_WAITS) ? CAN_WAITS : XRAM_WAITS;
  localparam int unsigned CNT_W     = $clog2(MAX_WAITS + 2);
  localparam int unsigned HI_W      = ADDR_W - SEG_W;

  rgn_e              rgn;
  logic              misaligned;
  logic              onchip_act;
  logic [CNT_W-1:0]  need;
  logic              wait_done;
  logic [DATA_W-1:0] raw_rdata;

  bus_region_map #(
    .ADDR_W   (ADDR_W),
    .XRAM_AW  (XRAM_AW),
    .CAN_AW   (CAN_AW)
  ) i_map (
    .valid      (req_valid),
    .addr       (req_addr),
    .is_byte    (req_byte),
    .onchip_en  (onchip_en),
    .rgn        (rgn),
    .misaligned (misaligned)
  );

  assign onchip_act = (rgn == RGN_XRAM) || (rgn == RGN_CAN);
  assign need       = (rgn == RGN_CAN) ? CNT_W'(CAN_WAITS) : CNT_W'(XRAM_WAITS);

  bus_wait_count #(.CNT_W(CNT_W)) i_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (onchip_act),
    .need   (need),
    .done   (wait_done)
  );

  always_comb begin
    case (rgn)
      RGN_XRAM: raw_rdata = xram_rdata;
      RGN_CAN:  raw_rdata = can_rdata;
      default:  raw_rdata = ext_rdata;
    endcase
  end

  bus_lane_steer #(.DATA_W(DATA_W)) i_lane (
    .is_byte   (req_byte),
    .odd       (req_addr[0]),
    .wdata_in  (req_wdata),
    .rdata_in  (raw_rdata),
    .be        (tgt_be),
    .wdata_out (tgt_wdata),
    .rdata_out (rsp_rdata)
  );

  assign xram_sel      = (rgn == RGN_XRAM);
  assign can_sel       = (rgn == RGN_CAN);
  assign ext_sel       = (rgn == RGN_EXT);
  assign xram_word     = req_addr[XRAM_AW-1:1];
  assign can_word      = req_addr[CAN_AW-1:1];
  assign tgt_we        = req_write && (rgn != RGN_NONE);
  assign rsp_align_err = misaligned;

  generate
    if (HI_W > 0) begin : g_seg
      assign ext_addr = onchip_en ? {{HI_W{1'b0}}, req_addr[SEG_W-1:0]} : req_addr;
    end else begin : g_noseg
      assign ext_addr = req_addr;
    end
  endgenerate

  always_comb begin
    case (rgn)
      RGN_XRAM, RGN_CAN: rsp_ready = wait_done;
      RGN_EXT:           rsp_ready = ext_ready;
      default:           rsp_ready = misaligned;
    endcase
  end
endmodule

// File: rtl/bus_region_decoder_chk.sv
module bus_region_decoder_chk #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned SEG_W     = 20,
  parameter int unsigned CAN_WAITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              onchip_en,
  input logic              rsp_ready,
  input logic              rsp_align_err,
  input logic              xram_sel,
  input logic              can_sel,
  input logic              ext_sel,
  input logic [ADDR_W-1:0] ext_addr
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (can_sel && !rsp_ready) run_q <= run_q + 1'b1;
    else                         run_q <= '0;
  end

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xram_sel, can_sel, ext_sel}));

  // R2
  xram_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_sel |-> rsp_ready);

  // R3
  can_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_sel && rsp_ready) |-> (run_q == 4'(CAN_WAITS)));

  // R4
  disabled_offchip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !onchip_en |-> (!xram_sel && !can_sel));

  // R6
  seg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && onchip_en) |-> (ext_addr[ADDR_W-1:SEG_W] == '0));

  // R9
  align_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_align_err |-> (rsp_ready && !xram_sel && !can_sel && !ext_sel));
endmodule

bind bus_region_decoder bus_region_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .SEG_W     (SEG_W),
  .CAN_WAITS (CAN_WAITS)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .onchip_en     (onchip_en),
  .rsp_ready     (rsp_ready),
  .rsp_align_err (rsp_align_err),
  .xram_sel      (xram_sel),
  .can_sel       (can_sel),
  .ext_sel       (ext_sel),
  .ext_addr      (ext_addr)
);

// File: tb/test_bus_region_decoder.sv
module test_bus_region_decoder;
  logic        clk;
  logic        rst_n;
  logic        onchip_en;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_write;
  logic        req_byte;
  logic [15:0] req_wdata;
  logic        rsp_ready;
  logic [15:0] rsp_rdata;
  logic        rsp_align_err;
  logic        tgt_we;
  logic [1:0]  tgt_be;
  logic [15:0] tgt_wdata;
  logic        xram_sel;
  logic [9:0]  xram_word;
  logic [15:0] xram_rdata;
  logic        can_sel;
  logic [6:0]  can_word;
  logic [15:0] can_rdata;
  logic        ext_sel;
  logic [23:0] ext_addr;
  logic [15:0] ext_rdata;
  logic        ext_ready;

  int n_chk = 0;
  int n_err = 0;

  bus_region_decoder i_bus_region_decoder (
    .clk(clk), .rst_n(rst_n), .onchip_en(onchip_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_byte(req_byte), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_align_err(rsp_align_err),
    .tgt_we(tgt_we), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
    .xram_sel(xram_sel), .xram_word(xram_word), .xram_rdata(xram_rdata),
    .can_sel(can_sel), .can_word(can_word), .can_rdata(can_rdata),
    .ext_sel(ext_sel), .ext_addr(ext_addr), .ext_rdata(ext_rdata),
    .ext_ready(ext_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [23:0] a, input logic wr, input logic by,
                         input logic [15:0] wd);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_byte = by; req_wdata = wd;
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
  endtask

  task automatic t_reset_state();
    #2;
    check("R1 reset xram_sel", 32'(xram_sel), 0);
    check("R3 reset can_sel", 32'(can_sel), 0);
    check("R5 reset ext_sel/ready", {ext_sel, rsp_ready}, 0);
  endtask

  task automatic t_xram_word();
    @(negedge clk);
    onchip_en = 1'b1; xram_rdata = 16'h1234;
    present(24'h00E7FE, 1'b0, 1'b0, 16'h0);
    #2;
    check("R1 xram_sel", {xram_sel, can_sel, ext_sel}, 3'b100);
    check("R1 xram_word", 32'(xram_word), 10'h3FF);
    check("R2 ready same cycle", 32'(rsp_ready), 1);
    check("R2 rdata", 32'(rsp_rdata), 16'h1234);
    go_idle();
  endtask

  task automatic t_xram_bytes();
    @(negedge clk);
    present(24'h00E011, 1'b1, 1'b1, 16'h00C3);
    #2;
    check("R7 odd byte be", 32'(tgt_be), 2'b10);
    check("R7 byte wdata", 32'(tgt_wdata), 16'hC3C3);
    check("R7 we", 32'(tgt_we), 1);
    @(negedge clk);
    xram_rdata = 16'hA55A;
    present(24'h00E011, 1'b0, 1'b1, 16'h0);
    #2;
    check("R8 odd byte read", 32'(rsp_rdata), 16'h00A5);
    @(negedge clk);
    present(24'h00E010, 1'b0, 1'b1, 16'h0);
    #2;
    check("R8 even byte read", 32'(rsp_rdata), 16'h005A);
    check("R7 even byte be", 32'(tgt_be), 2'b01);
    @(negedge clk);
    present(24'h00E010, 1'b1, 1'b0, 16'hBEEF);
    #2;
    check("R7 word be/data", {tgt_be, tgt_wdata}, {2'b11, 16'hBEEF});
    go_idle();
  endtask

  task automatic can_seq(input string tag);
    #2;
    check({tag, " wait1"}, 32'(rsp_ready), 0);
    @(negedge clk); #2;
    check({tag, " wait2"}, 32'(rsp_ready), 0);
    @(negedge clk); #2;
    check({tag, " ready"}, 32'(rsp_ready), 1);
  endtask

  task automatic t_can();
    @(negedge clk);
    can_rdata = 16'h7E81;
    present(24'h00EF04, 1'b0, 1'b0, 16'h0);
    #2;
    check("R3 can_sel/word", {can_sel, 7'(can_word)}, {1'b1, 7'h02});
    check("R3 can rdata", 32'(rsp_rdata), 16'h7E81);
    can_seq("R3");
    @(negedge clk);
    present(24'h00EFFF, 1'b0, 1'b1, 16'h0);
    can_seq("R11");
    check("R11 byte rdata", 32'(rsp_rdata), 16'h007E);
    go_idle();
  endtask

  task automatic t_disabled();
    @(negedge clk);
    onchip_en = 1'b0;
    present(24'h00E100, 1'b0, 1'b0, 16'h0);
    #2;
    check("R4 xram window sels", {xram_sel, can_sel, ext_sel}, 3'b001);
    check("R4 ext_addr", 32'(ext_addr), 24'h00E100);
    @(negedge clk);
    present(24'h00EF10, 1'b0, 1'b0, 16'h0);
    #2;
    check("R4 can window sels", {xram_sel, can_sel, ext_sel}, 3'b001);
    go_idle();
    onchip_en = 1'b1;
  endtask

  task automatic t_ext();
    @(negedge clk);
    ext_ready = 1'b0; ext_rdata = 16'h5AA5;
    present(24'h012344, 1'b0, 1'b0, 16'h0);
    #2;
    check("R5 ext_sel", 32'(ext_sel), 1);
    check("R5 ready waits for ext", 32'(rsp_ready), 0);
    @(negedge clk);
    ext_ready = 1'b1;
    #2;
    check("R5 ready follows ext", 32'(rsp_ready), 1);
    check("R5 ext rdata", 32'(rsp_rdata), 16'h5AA5);
    go_idle();
  endtask

  task automatic t_segment();
    @(negedge clk);
    onchip_en = 1'b1;
    present(24'h9A3456, 1'b0, 1'b0, 16'h0);
    #2;
    check("R6 limited addr", 32'(ext_addr), 24'h0A3456);
    @(negedge clk);
    onchip_en = 1'b0;
    #2;
    check("R6 full addr", 32'(ext_addr), 24'h9A3456);
    go_idle();
    onchip_en = 1'b1;
  endtask

  task automatic t_align();
    @(negedge clk);
    present(24'h00E001, 1'b1, 1'b0, 16'h1111);
    #2;
    check("R9 align err", {rsp_align_err, rsp_ready}, 2'b11);
    check("R9 no select", {xram_sel, can_sel, ext_sel, tgt_we}, 0);
    @(negedge clk);
    present(24'h100001, 1'b0, 1'b0, 16'h0);
    #2;
    check("R9 ext odd word", {rsp_align_err, ext_sel}, 2'b10);
    go_idle();
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    present(24'h00EF20, 1'b0, 1'b0, 16'h0);
    #2;
    check("R10 pre wait", 32'(rsp_ready), 0);
    @(negedge clk);
    rst_n = 1'b0; #2; rst_n = 1'b1;
    can_seq("R10");
    go_idle();
  endtask

  initial begin
    rst_n = 1'b0; onchip_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_write = 1'b0; req_byte = 1'b0; req_wdata = '0;
    xram_rdata = '0; can_rdata = '0; ext_rdata = '0; ext_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    t_xram_word();
    t_xram_bytes();
    t_can();
    t_disabled();
    t_ext();
    t_segment();
    t_align();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule